// File: doc/BRIEF.md
# Write-Through Direct-Mapped Word Cache

This block sits between a processor port and a slower main-memory port. It holds a set of word-sized slots, each with a valid flag, an address tag and one 32-bit data word. A read looks up exactly one slot, chosen by the index bits of the byte address, and reports a hit when that slot is valid and its stored tag equals the tag bits of the address. On a hit the word is returned in the same cycle without a stall.

A read miss raises the stall signal and fetches the single word from memory. When memory acknowledges, the word is installed in the slot. The processor keeps presenting the same read every cycle, and the retry after the install hits. A store never checks the tag. It overwrites the indexed slot's tag and data, marks the slot valid, and forwards the word to memory. Further requests stall until memory acknowledges that write.

The number of slots is set by the `INDEX_W` parameter. The default is 10 index bits, which gives 1K slots. Setting `INDEX_W` to 14 gives 16K slots with a 16-bit tag, which is 64 KB of data.

Top module: `wt_dm_cache`

## Requirements
- R1: The byte address splits as offset = bits 1:0 (ignored by lookup), index = bits INDEX_W+1:2, tag = bits 31:INDEX_W+2. Addresses differing only in bits 1:0 reach the same slot, and addresses issued to memory have bits 1:0 cleared.
- R2: Reset (synchronous, active high) clears every valid flag and returns the controller to idle, with `cpu_stall` and `mem_req` low. The first read of any address after reset misses.
- R3: A read whose slot is valid with a matching tag completes in the same cycle: `cpu_stall` is low, `cpu_rdata` is the stored word, and no memory request starts.
- R4: A read whose slot is invalid or holds a different tag is a miss: `cpu_stall` is high in that cycle.
- R5: After a read miss, from the next cycle `mem_req`=1 and `mem_we`=0, with `mem_addr` equal to the word-aligned read address. In the cycle `mem_ack` is high, `mem_rdata` is installed with the new tag and valid set. The retried read then hits with that word.
- R6: A store presented while idle is accepted in the same cycle (`cpu_stall` low) without any tag check. It overwrites the slot's tag and data and sets valid.
- R7: After an accepted store, from the next cycle `mem_req`=1 and `mem_we`=1, with `mem_addr` equal to the word-aligned store address and `mem_wdata` equal to the stored word, until `mem_ack`.
- R8: While a memory transaction is outstanding, `cpu_stall` is high for every request, and no request is accepted.
- R9: A read of the stored address issued right after a store returns the newly stored word once it is accepted, with no memory read.
- R10: While `mem_req` is high and `mem_ack` low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read data, meaningful on an accepted read |
| cpu_stall | output | 1 | Request not accepted this cycle |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = write-through, 0 = fill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-through data |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the pending transaction |

## Verification
The bench targets slot reuse. A read to an index whose slot holds another tag must refetch; a design that compared only valid, or only part of the tag, would return a stale word. It also runs a store to a slot holding another tag, followed at once by a read of the same address. A design that checked the tag before writing, or allocated through memory, would fetch instead of returning the new word. After the slot is evicted and the address is reread, the fetched value shows whether the write-through reached memory.

Memory latency is varied from zero to several cycles, with requests held during busy periods. A design that dropped the stall, or let its memory request drift before the acknowledge, would then disagree with the reference model.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int BYTE_OFS_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WTHRU = 2'd2
    } wtc_state_e;

    function automatic logic [31:0] word_align(input logic [31:0] a);
        return {a[31:BYTE_OFS_W], {BYTE_OFS_W{1'b0}}};
    endfunction

endpackage

// File: rtl/wtc_slot_store.sv
module wtc_slot_store #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_data
);
    localparam int SLOTS = 1 << INDEX_W;

    logic [SLOTS-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [SLOTS];
    logic [DATA_W-1:0] data_q [SLOTS];

    // valid flags are the only state needing reset
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // R6: any slot write leaves that slot valid
    a_r6_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/wtc_lookup.sv
module wtc_lookup #(
    parameter int TAG_W = 20
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TAG_W-1:0] addr_tag,
    output logic             hit
);
    always_comb begin
        hit = slot_valid && (slot_tag == addr_tag);
    end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int INDEX_W = 10,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [31:0]        cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               hit,
    output logic               cpu_stall,
    output logic               wr_en,
    output logic [INDEX_W-1:0] wr_idx,
    output logic [31-INDEX_W-BYTE_OFS_W:0] wr_tag,
    output logic [DATA_W-1:0]  wr_data,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ack
);
    localparam int IDX_LO = BYTE_OFS_W;
    localparam int IDX_HI = BYTE_OFS_W + INDEX_W - 1;
    localparam int TAG_LO = IDX_HI + 1;

    wtc_state_e        state_q;
    logic [31:0]       maddr_q;
    logic [DATA_W-1:0] mwdata_q;
    logic              store_go;
    logic              fill_done;
    logic              idle;

    assign idle      = (state_q == ST_IDLE);
    assign store_go  = idle && cpu_req && cpu_we;
    assign fill_done = (state_q == ST_FILL) && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            maddr_q  <= '0;
            mwdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req && cpu_we) begin
                        maddr_q  <= word_align(cpu_addr);
                        mwdata_q <= cpu_wdata;
                        state_q  <= ST_WTHRU;
                    end else if (cpu_req && !hit) begin
                        maddr_q  <= word_align(cpu_addr);
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL, ST_WTHRU: begin
                    if (mem_ack) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_stall = !idle || (cpu_req && !cpu_we && !hit);
        wr_en     = store_go || fill_done;
        wr_idx    = store_go ? cpu_addr[IDX_HI:IDX_LO] : maddr_q[IDX_HI:IDX_LO];
        wr_tag    = store_go ? cpu_addr[31:TAG_LO]     : maddr_q[31:TAG_LO];
        wr_data   = store_go ? cpu_wdata               : mem_rdata;
        mem_req   = !idle;
        mem_we    = (state_q == ST_WTHRU);
        mem_addr  = maddr_q;
        mem_wdata = mwdata_q;
    end

    // R7: an accepted store is forwarded to memory on the next cycle
    a_r7_store_forwarded: assert property (@(posedge clk) disable iff (rst)
        store_go |=> (mem_req && mem_we && mem_wdata == $past(cpu_wdata)
                      && mem_addr[31:IDX_LO] == $past(cpu_addr[31:IDX_LO])));

    // R5: a read miss launches a memory read
    a_r5_miss_fetches: assert property (@(posedge clk) disable iff (rst)
        (idle && cpu_req && !cpu_we && !hit) |=> (mem_req && !mem_we));

    // R10: memory command holds until acknowledged
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache
    import wtc_pkg::*;
#(
    parameter int INDEX_W = 10,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W  = 32 - INDEX_W - BYTE_OFS_W;
    localparam int IDX_LO = BYTE_OFS_W;
    localparam int IDX_HI = BYTE_OFS_W + INDEX_W - 1;

    logic               rd_valid;
    logic [TAG_W-1:0]   rd_tag;
    logic               hit;
    logic               wr_en;
    logic [INDEX_W-1:0] wr_idx;
    logic [TAG_W-1:0]   wr_tag;
    logic [DATA_W-1:0]  wr_data;

    wtc_slot_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (cpu_addr[IDX_HI:IDX_LO]),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (cpu_rdata),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    wtc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .slot_valid (rd_valid),
        .slot_tag   (rd_tag),
        .addr_tag   (cpu_addr[31:IDX_HI+1]),
        .hit        (hit)
    );

    wtc_ctrl #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .hit       (hit),
        .cpu_stall (cpu_stall),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    // R4: an accepted read always comes from a valid slot
    a_r4_accept_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && !cpu_stall) |-> rd_valid);

endmodule

// File: tb/test_wt_dm_cache.sv
module test_wt_dm_cache;
    localparam int IW = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack;

    always #4 clk = ~clk;

    wt_dm_cache #(.INDEX_W(IW)) i_wt_dm_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    bit          m_vld [int];
    logic [31:0] m_tag [int];
    logic [31:0] m_dat [int];
    logic [31:0] m_mem [int];
    int          ms;     // 0 idle, 1 fill, 2 write-through
    logic [31:0] m_addr, m_wdata;
    int          cnt;
    int          lat = 1;
    string       cur_tag = "R3";
    bit          after_reset = 0;

    function automatic logic [31:0] mem_init(logic [31:0] a);
        return {a[15:0] ^ 16'h5a3c, a[31:16] ^ 16'hc3e1};
    endfunction

    function automatic logic [31:0] mread(logic [31:0] a);
        int k = int'(a >> 2);
        if (m_mem.exists(k)) return m_mem[k];
        return mem_init(a & 32'hffff_fffc);
    endfunction

    function automatic int idx_of(logic [31:0] a);
        return int'((a >> 2) & ((32'd1 << IW) - 1));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit rq, bit w, logic [31:0] a, logic [31:0] d, output bit accepted);
        bit hit, ack, exp_stall;
        int ix;
        string st;
        ix = idx_of(a);
        hit = m_vld.exists(ix) && m_vld[ix] && (m_tag[ix] == (a >> (IW + 2)));
        ack = (ms != 0) && (cnt >= lat);
        cpu_req = rq; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        mem_ack = ack;
        mem_rdata = (ack && ms == 1) ? mread(m_addr) : 32'h0;
        exp_stall = (ms != 0) || (rq && !w && !hit);
        #1;
        if (ms != 0) st = "R8";
        else if (!rq) st = "R2";
        else if (w) st = "R6";
        else if (hit) st = "R3";
        else st = after_reset ? "R2" : "R4";
        chk(st, {31'd0, cpu_stall}, {31'd0, exp_stall});
        chk((ms == 0) ? "R2" : (cnt > 0 ? "R10" : (ms == 1 ? "R5" : "R7")),
            {31'd0, mem_req}, {31'd0, ms != 0});
        if (ms != 0) begin
            chk(cnt > 0 ? "R10" : (ms == 1 ? "R5" : "R7"), {31'd0, mem_we}, {31'd0, ms == 2});
            chk(ms == 1 ? "R5" : "R7", mem_addr, m_addr);
            if (ms == 2) chk("R7", mem_wdata, m_wdata);
        end
        if (rq && !w && !exp_stall) chk(cur_tag, cpu_rdata, m_dat[ix]);
        accepted = rq && !exp_stall;
        @(posedge clk);
        if (ms == 0) begin
            if (rq && w) begin
                m_vld[ix] = 1; m_tag[ix] = a >> (IW + 2); m_dat[ix] = d;
                m_mem[int'(a >> 2)] = d;
                ms = 2; m_addr = a & 32'hffff_fffc; m_wdata = d; cnt = 0;
            end else if (rq && !hit) begin
                ms = 1; m_addr = a & 32'hffff_fffc; cnt = 0;
            end
        end else if (ack) begin
            if (ms == 1) begin
                m_vld[idx_of(m_addr)] = 1;
                m_tag[idx_of(m_addr)] = m_addr >> (IW + 2);
                m_dat[idx_of(m_addr)] = mread(m_addr);
            end
            ms = 0;
        end else cnt++;
        @(negedge clk);
    endtask

    task automatic do_op(bit w, logic [31:0] a, logic [31:0] d);
        bit acc = 0;
        for (int g = 0; g < 40 && !acc; g++) step(1'b1, w, a, d, acc);
        if (!acc) begin
            n_chk++; n_bad++;
            $display("FAIL R8: request never accepted, actual stalled expected accepted");
        end
        after_reset = 0;
    endtask

    task automatic idle_cycles(int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0, 32'h0, acc);
    endtask

    initial begin
        #160000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        logic [31:0] alias_a;
        rst = 1; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        mem_ack = 0; mem_rdata = 0; ms = 0; cnt = 0; m_addr = 0; m_wdata = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R2: idle after reset, then first reads miss
        idle_cycles(2);
        cur_tag = "R5";
        after_reset = 1; do_op(1'b0, 32'h0000_0010, 0);
        after_reset = 1; do_op(1'b0, 32'h1234_5678, 0);
        // R3: repeated read hits
        cur_tag = "R3";
        do_op(1'b0, 32'h0000_0010, 0);
        // R1: offset bits ignored
        cur_tag = "R1";
        do_op(1'b0, 32'h0000_0013, 0);
        do_op(1'b0, 32'h1234_5679, 0);
        // R4: same index, other tag -> refill
        cur_tag = "R4";
        alias_a = 32'h0000_0010 + (32'd1 << (IW + 2));
        do_op(1'b0, alias_a, 0);
        do_op(1'b0, 32'h0000_0010, 0);
        // R6/R9: store over a slot with another tag, read at once
        cur_tag = "R9";
        lat = 2;
        do_op(1'b1, alias_a, 32'hdead_beef);
        do_op(1'b0, alias_a, 0);
        // R6: store into a never-filled slot, then read without a fill
        cur_tag = "R6";
        do_op(1'b1, 32'h0abc_0104, 32'h0bad_f00d);
        idle_cycles(3);
        do_op(1'b0, 32'h0abc_0106, 0);
        // R7: evict, reread -> memory holds the written word
        cur_tag = "R7";
        do_op(1'b0, 32'h0000_0010, 0);
        do_op(1'b0, alias_a, 0);
        // R8/R10: long latency, back-to-back requests
        cur_tag = "R8";
        lat = 4;
        do_op(1'b0, 32'h5555_0020, 0);
        do_op(1'b1, 32'h5555_0024, 32'h1111_2222);
        do_op(1'b1, 32'h5555_0028, 32'h3333_4444);
        do_op(1'b0, 32'h5555_0024, 0);
        lat = 0;
        do_op(1'b0, 32'h6666_0030, 0);
        do_op(1'b1, 32'h6666_0030, 32'h7777_8888);
        do_op(1'b0, 32'h6666_0030, 0);
        // mixed traffic over a small conflict-heavy address set
        cur_tag = "R3";
        base = 32'h0000_0040;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = base + ((i * 7 % 5) << (IW + 2)) + ((i * 3 % 4) << 2) + (i % 4);
            lat = (i * 5) % 4;
            if ((i % 3) == 1) do_op(1'b1, a, 32'hc0de_0000 + i);
            else do_op(1'b0, a, 0);
            if ((i % 11) == 0) idle_cycles(1);
        end
        idle_cycles(6);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule